// File: doc/BRIEF.md
# Dual Transmit Channel Request Arbiter

Two transmit channels share a single transmit FIFO, so only one of them may hold the path to the descriptor-driven memory engine at any moment. This block decides which channel may raise a packet request and when. It keeps each channel's go bit, the shared go bit of dependent operation and the per-channel error status flags. Software sets a go bit, and hardware clears it on its own terms. The memory engine answers each request with either an acknowledge or a descriptor-not-ready response, and later reports the end of the packet with a done strobe.

Each channel carries a 2-bit mode. A single-packet channel sends one packet per go bit. A multiple-packet channel keeps requesting while its other conditions hold. When both mode fields select dependent operation, the two channels share one go bit and take turns as if they were one channel. After a descriptor stall in that mode, the channel that stalled resumes first, whatever the first-channel select says.

Top module: `txreq_arb`

## Requirements
- R1: At most one channel is busy at a time, where busy means requesting or transferring. A raised request stays high until the engine answers it with `req_ack` or `desc_nr`.
- R2: Mode encoding is 00 for single-packet, 01 for multiple-packet, 10 for dependent and 11 reserved. Dependent operation applies only when both mode fields are 10. A channel whose mode is 11 never requests, even when its go bit is 1.
- R3: A single-packet channel requests once. Its go bit is cleared in the cycle after the acknowledge, `go_clr` pulses in that same cycle, and it does not request again until software sets the go bit again.
- R4: A new request is raised only while both channels are idle and `fifo_room` is 1. The request shows on `req` one cycle after these conditions first hold, so two cycles after a `pkt_done` strobe.
- R5: In independent modes, a `desc_nr` response clears that channel's go bit and pulses `go_clr`. The channel then stays silent.
- R6: An error during a transfer whose kind is not masked (`tx_err` with `mask_tx`=0, `sqe_err` with `mask_sqe`=0) ends the packet, clears the active channel's go bit and sets its `err_stat` bit. It also sets the cause bit: bit 0 for a transmit error, bit 1 for an SQE error. A masked error has no effect. Both kinds of flag are cleared by writing 1 to the matching clear bit.
- R7: A channel whose `err_stat` bit is set does not request, even with its go bit at 1. It resumes once the flag is cleared and its go bit is 1.
- R8: When both channels are eligible together in independent modes, the one not granted most recently is granted, so two multiple-packet channels alternate.
- R9: In dependent mode, setting the shared go bit starts with the channel named by `first_sel`, and grants then alternate between the channels.
- R10: In dependent mode, `desc_nr` on either channel clears the shared go bit and pulses `dep_go_clr`. On the next setting of the shared go bit, the stalled channel requests first regardless of `first_sel`.
- R11: When a hardware clear and a software set of a go bit fall in the same cycle, the go bit ends up 0.
- R12: After reset, no request is raised and all go bits, strobes, status flags and cause flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch0_mode | input | 2 | Mode of channel 0 |
| ch1_mode | input | 2 | Mode of channel 1 |
| go_set | input | 2 | Software set strobes for the per-channel go bits |
| dep_go_set | input | 1 | Software set strobe for the shared dependent go bit |
| first_sel | input | 1 | Channel that starts a fresh dependent run |
| fifo_room | input | 1 | FIFO can accept another packet |
| req_ack | input | 2 | Engine accepted the request of a channel |
| pkt_done | input | 2 | Packet transfer of a channel finished |
| desc_nr | input | 2 | Engine answered a request with descriptor not ready |
| tx_err | input | 1 | Transmit error on the active channel |
| sqe_err | input | 1 | SQE error on the active channel |
| mask_tx | input | 1 | Masks transmit errors |
| mask_sqe | input | 1 | Masks SQE errors |
| stat_clr | input | 2 | Write-one-to-clear for the error status flags |
| cause_clr | input | 2 | Write-one-to-clear for the cause flags |
| req | output | 2 | Per-channel packet request |
| go | output | 2 | Per-channel go bits |
| dep_go | output | 1 | Shared dependent go bit |
| go_clr | output | 2 | Pulse: hardware cleared a channel go bit |
| dep_go_clr | output | 1 | Pulse: hardware cleared the shared go bit |
| err_stat | output | 2 | Per-channel error status flags |
| err_cause | output | 2 | Error cause flags (bit 0 transmit, bit 1 SQE) |

## Verification
The bench targets the resume order after a dependent stall with `first_sel` flipped. A design that reloaded the select bit would restart on the wrong channel. It also drives a software set in the same cycle as an acknowledge that clears the go bit. If the wrong side won that race, a single-packet channel would send an extra packet. It holds `fifo_room` low after a packet to catch a request raised too early. It also blocks a channel through a set error flag while its go bit is 1, which catches a design that resumes on the go bit alone. Finally, it checks the order of turns when both multiple-packet channels become eligible in the same cycle, which exposes a fixed-priority arbiter that starves one channel.

// File: rtl/txarb_pkg.sv
package txarb_pkg;

   typedef enum logic [1:0] {
      MD_SINGLE = 2'b00,
      MD_MULTI  = 2'b01,
      MD_DEP    = 2'b10,
      MD_RSVD   = 2'b11
   } txmode_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_REQ  = 2'b01,
      PH_ACT  = 2'b10
   } phase_e;

endpackage

// File: rtl/txarb_chan.sv
module txarb_chan
   import txarb_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              dep,
   input  logic              grant,
   input  logic              ack,
   input  logic              nr,
   input  logic              done,
   input  logic              err_evt,
   input  logic              go_set,
   input  logic              stat_clr,
   output logic              req,
   output logic              idle,
   output logic              elig,
   output logic              go,
   output logic              stat,
   output logic              clr_go,
   output logic              nr_hit,
   output logic              err_hit
);

   phase_e ph, ph_n;
   logic   is_single, is_multi;

   assign is_single = (mode == MD_SINGLE);
   assign is_multi  = (mode == MD_MULTI);
   assign nr_hit    = (ph == PH_REQ) && nr;
   assign err_hit   = (ph == PH_ACT) && err_evt;
   assign clr_go    = !dep && (((ph == PH_REQ) && ack && !nr && is_single) || nr_hit || err_hit);
   assign req       = (ph == PH_REQ);
   assign idle      = (ph == PH_IDLE);
   assign elig      = !dep && go && !stat && (is_single || is_multi) && idle;

   always_comb begin
      ph_n = ph;
      unique case (ph)
         PH_IDLE: if (grant) ph_n = PH_REQ;
         PH_REQ: begin
            if (nr)       ph_n = PH_IDLE;
            else if (ack) ph_n = PH_ACT;
         end
         PH_ACT:  if (done || err_evt) ph_n = PH_IDLE;
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         go   <= 1'b0;
         stat <= 1'b0;
      end else begin
         ph   <= ph_n;
         go   <= (go | go_set) & ~clr_go;
         stat <= err_hit | (stat & ~stat_clr);
      end
   end

   a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack && !nr) |=> req);

   a_r3_single_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!dep && is_single && req && ack && !nr) |=> !go);

   a_r5_nr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!dep && nr_hit) |=> !go);

   a_r6_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      err_hit |=> (stat && idle));

   a_r7_stat_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && stat) |=> idle);

   a_r11_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_go && go_set) |=> !go);

endmodule

// File: rtl/txarb_pick.sv
module txarb_pick #(
   parameter int NUM_CH   = 2,
   parameter int FIRST_CH = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dep,
   input  logic              dep_go_set,
   input  logic              first_sel,
   input  logic              fifo_room,
   input  logic [NUM_CH-1:0] idle,
   input  logic [NUM_CH-1:0] elig,
   input  logic [NUM_CH-1:0] stat,
   input  logic [NUM_CH-1:0] nr_hit,
   input  logic [NUM_CH-1:0] err_hit,
   output logic [NUM_CH-1:0] grant,
   output logic              dep_go,
   output logic              dep_clr
);

   logic nxt;
   logic stall;
   logic last;

   assign dep_clr = dep && ((|nr_hit) || (|err_hit));

   always_comb begin
      grant = '0;
      if (fifo_room && (&idle)) begin
         if (dep) begin
            if (dep_go && !stat[nxt]) grant[nxt] = 1'b1;
         end else if (&elig) begin
            grant[~last] = 1'b1;
         end else begin
            grant = elig;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dep_go <= 1'b0;
         nxt    <= 1'b0;
         stall  <= 1'b0;
         last   <= (FIRST_CH == 0) ? 1'b1 : 1'b0;
      end else begin
         if (|grant) last <= grant[1];
         if (dep_clr)         dep_go <= 1'b0;
         else if (dep_go_set) dep_go <= 1'b1;
         if (dep && (|nr_hit)) begin
            nxt   <= nr_hit[1];
            stall <= 1'b1;
         end else if (dep && (|grant)) begin
            nxt <= grant[0];
         end else if (dep_go_set && !dep_go) begin
            nxt   <= stall ? nxt : first_sel;
            stall <= 1'b0;
         end
      end
   end

   a_r4_room_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> (fifo_room && (&idle) && $onehot(grant)));

   a_r10_dep_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (dep && (|nr_hit)) |=> !dep_go);

   a_r9_dep_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (dep && grant[0] && !(|nr_hit)) |=> nxt);

endmodule

// File: rtl/txreq_arb.sv
module txreq_arb #(
   parameter int NUM_CH      = 2,
   parameter int MODE_W      = 2,
   parameter int FIRST_CH    = 0,
   parameter bit REG_STROBES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ch0_mode,
   input  logic [1:0]       ch1_mode,
   input  logic [1:0]       go_set,
   input  logic             dep_go_set,
   input  logic             first_sel,
   input  logic             fifo_room,
   input  logic [1:0]       req_ack,
   input  logic [1:0]       pkt_done,
   input  logic [1:0]       desc_nr,
   input  logic             tx_err,
   input  logic             sqe_err,
   input  logic             mask_tx,
   input  logic             mask_sqe,
   input  logic [1:0]       stat_clr,
   input  logic [1:0]       cause_clr,
   output logic [1:0]       req,
   output logic [1:0]       go,
   output logic             dep_go,
   output logic [1:0]       go_clr,
   output logic             dep_go_clr,
   output logic [1:0]       err_stat,
   output logic [1:0]       err_cause
);
   import txarb_pkg::*;

   localparam int CAUSE_W = 2;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("txreq_arb supports exactly two channels");
   end
   if (MODE_W != 2) begin : g_bad_mode
      $error("txreq_arb mode field must be 2 bits");
   end
   if (FIRST_CH < 0 || FIRST_CH >= NUM_CH) begin : g_bad_first
      $error("FIRST_CH out of range");
   end

   logic [MODE_W-1:0] mode_v [NUM_CH];
   logic [NUM_CH-1:0] idle_w, elig_w, clr_w, nr_w, errh_w, grant_w;
   logic              dep, err_evt, dep_clr_w;
   logic              tx_hit, sqe_hit;

   assign mode_v[0] = ch0_mode;
   assign mode_v[1] = ch1_mode;
   assign dep       = (ch0_mode == MD_DEP) && (ch1_mode == MD_DEP);
   assign tx_hit    = tx_err && !mask_tx;
   assign sqe_hit   = sqe_err && !mask_sqe;
   assign err_evt   = tx_hit || sqe_hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      txarb_chan #(.MODE_W(MODE_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode     (mode_v[c]),
         .dep      (dep),
         .grant    (grant_w[c]),
         .ack      (req_ack[c]),
         .nr       (desc_nr[c]),
         .done     (pkt_done[c]),
         .err_evt  (err_evt),
         .go_set   (go_set[c]),
         .stat_clr (stat_clr[c]),
         .req      (req[c]),
         .idle     (idle_w[c]),
         .elig     (elig_w[c]),
         .go       (go[c]),
         .stat     (err_stat[c]),
         .clr_go   (clr_w[c]),
         .nr_hit   (nr_w[c]),
         .err_hit  (errh_w[c])
      );
   end

   txarb_pick #(.NUM_CH(NUM_CH), .FIRST_CH(FIRST_CH)) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .dep        (dep),
      .dep_go_set (dep_go_set),
      .first_sel  (first_sel),
      .fifo_room  (fifo_room),
      .idle       (idle_w),
      .elig       (elig_w),
      .stat       (err_stat),
      .nr_hit     (nr_w),
      .err_hit    (errh_w),
      .grant      (grant_w),
      .dep_go     (dep_go),
      .dep_clr    (dep_clr_w)
   );

   logic [CAUSE_W-1:0] cause_set;
   assign cause_set = (|errh_w) ? {sqe_hit, tx_hit} : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_cause <= '0;
      else        err_cause <= cause_set | (err_cause & ~cause_clr);
   end

   if (REG_STROBES) begin : g_strobe_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            go_clr     <= '0;
            dep_go_clr <= 1'b0;
         end else begin
            go_clr     <= clr_w;
            dep_go_clr <= dep_clr_w;
         end
      end
   end else begin : g_strobe_comb
      assign go_clr     = clr_w;
      assign dep_go_clr = dep_clr_w;
   end

   a_r1_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~idle_w));

   a_r2_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ch0_mode == MD_RSVD && idle_w[0]) |=> !req[0]);

   a_r6_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
      ((|errh_w) && tx_hit) |=> err_cause[0]);

endmodule

// File: tb/txreq_arb_test.sv
module txreq_arb_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ch0_mode = 2'b00, ch1_mode = 2'b00;
   logic [1:0] go_set = '0, req_ack = '0, pkt_done = '0, desc_nr = '0;
   logic [1:0] stat_clr = '0, cause_clr = '0;
   logic       dep_go_set = 1'b0, first_sel = 1'b0, fifo_room = 1'b0;
   logic       tx_err = 1'b0, sqe_err = 1'b0, mask_tx = 1'b0, mask_sqe = 1'b0;
   logic [1:0] req, go, go_clr, err_stat, err_cause;
   logic       dep_go, dep_go_clr;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   txreq_arb uut (
      .clk(clk), .rst_n(rst_n), .ch0_mode(ch0_mode), .ch1_mode(ch1_mode),
      .go_set(go_set), .dep_go_set(dep_go_set), .first_sel(first_sel),
      .fifo_room(fifo_room), .req_ack(req_ack), .pkt_done(pkt_done),
      .desc_nr(desc_nr), .tx_err(tx_err), .sqe_err(sqe_err),
      .mask_tx(mask_tx), .mask_sqe(mask_sqe), .stat_clr(stat_clr),
      .cause_clr(cause_clr), .req(req), .go(go), .dep_go(dep_go),
      .go_clr(go_clr), .dep_go_clr(dep_go_clr), .err_stat(err_stat),
      .err_cause(err_cause)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic serve(input int ch);
      chk(req == 2'(1 << ch), "R1 only granted channel requests", int'(req), 1 << ch);
      req_ack[ch] = 1'b1;
      step(1);
      req_ack = '0;
      chk(req == 2'b00, "R1 request dropped after ack", int'(req), 0);
      pkt_done[ch] = 1'b1;
      step(1);
      pkt_done = '0;
   endtask

   task automatic t_reset();
      chk(req == 0, "R12 req", int'(req), 0);
      chk(go == 0 && dep_go == 0, "R12 go bits", int'({dep_go, go}), 0);
      chk(err_stat == 0 && err_cause == 0, "R12 flags", int'({err_stat, err_cause}), 0);
      chk(go_clr == 0 && dep_go_clr == 0, "R12 strobes", int'({dep_go_clr, go_clr}), 0);
   endtask

   task automatic t_single();
      ch0_mode = 2'b00; ch1_mode = 2'b00; fifo_room = 1'b1;
      go_set = 2'b01; step(1); go_set = '0; step(1);
      chk(req == 2'b01, "R3 first request", int'(req), 1);
      req_ack = 2'b01; step(1); req_ack = '0;
      chk(go[0] == 1'b0, "R3 go cleared", int'(go[0]), 0);
      chk(go_clr == 2'b01, "R3 go_clr pulse", int'(go_clr), 1);
      pkt_done = 2'b01; step(1); pkt_done = '0;
      step(3);
      chk(req == 2'b00, "R3 no second request", int'(req), 0);
      // R11: set and hardware clear in the same cycle
      go_set = 2'b01; step(1); go_set = '0; step(1);
      chk(req == 2'b01, "R11 request before race", int'(req), 1);
      req_ack = 2'b01; go_set = 2'b01; step(1); req_ack = '0; go_set = '0;
      chk(go[0] == 1'b0, "R11 clear beats set", int'(go[0]), 0);
      pkt_done = 2'b01; step(1); pkt_done = '0; step(2);
      chk(req == 2'b00, "R11 no extra packet", int'(req), 0);
   endtask

   task automatic t_multi();
      ch0_mode = 2'b01;
      go_set = 2'b01; step(1); go_set = '0; step(1);
      serve(0); step(1); serve(0);
      fifo_room = 1'b0; step(3);
      chk(req == 2'b00, "R4 held off without room", int'(req), 0);
      fifo_room = 1'b1; step(1);
      chk(req == 2'b01, "R4 request once room returns", int'(req), 1);
      desc_nr = 2'b01; step(1); desc_nr = '0;
      chk(go[0] == 1'b0 && go_clr == 2'b01, "R5 not-ready clears go", int'({go_clr, go}), 4);
      step(3);
      chk(req == 2'b00, "R5 channel silent", int'(req), 0);
   endtask

   task automatic t_turns();
      ch0_mode = 2'b01; ch1_mode = 2'b01;
      go_set = 2'b11; step(1); go_set = '0; step(1);
      serve(1); step(1); serve(0); step(1); serve(1); step(1);
      chk(req == 2'b01, "R8 turn returns to ch0", int'(req), 1);
      desc_nr = 2'b01; step(1); desc_nr = '0; step(1);
      chk(req == 2'b10, "R8 ch1 continues alone", int'(req), 2);
      desc_nr = 2'b10; step(1); desc_nr = '0;
      chk(go == 2'b00, "R5 both go bits cleared", int'(go), 0);
   endtask

   task automatic t_error();
      ch1_mode = 2'b01; mask_tx = 1'b0; mask_sqe = 1'b0;
      go_set = 2'b10; step(1); go_set = '0; step(1);
      chk(req == 2'b10, "R6 ch1 requests", int'(req), 2);
      req_ack = 2'b10; step(1); req_ack = '0;
      tx_err = 1'b1; step(1); tx_err = 1'b0;
      chk(err_stat == 2'b10, "R6 status set", int'(err_stat), 2);
      chk(err_cause == 2'b01, "R6 tx cause set", int'(err_cause), 1);
      chk(go[1] == 1'b0 && req == 2'b00, "R6 go cleared", int'({go[1], req}), 0);
      go_set = 2'b10; step(1); go_set = '0; step(3);
      chk(req == 2'b00 && go[1] == 1'b1, "R7 blocked by status", int'({go[1], req}), 4);
      stat_clr = 2'b10; step(1); stat_clr = '0; step(1);
      chk(req == 2'b10, "R7 resumes after clear", int'(req), 2);
      req_ack = 2'b10; step(1); req_ack = '0;
      mask_sqe = 1'b1; sqe_err = 1'b1; step(1); sqe_err = 1'b0;
      chk(err_stat == 2'b00 && err_cause == 2'b01 && go[1] == 1'b1,
          "R6 masked error ignored", int'({go[1], err_stat, err_cause}), 17);
      pkt_done = 2'b10; step(1); pkt_done = '0; step(1);
      chk(req == 2'b10, "R6 masked error left packet flow", int'(req), 2);
      desc_nr = 2'b10; step(1); desc_nr = '0;
      cause_clr = 2'b01; step(1); cause_clr = '0;
      chk(err_cause == 2'b00, "R6 cause cleared", int'(err_cause), 0);
      mask_sqe = 1'b0;
   endtask

   task automatic t_dep();
      ch0_mode = 2'b10; ch1_mode = 2'b10; first_sel = 1'b1;
      dep_go_set = 1'b1; step(1); dep_go_set = 1'b0; step(1);
      chk(req == 2'b10, "R9 first_sel picks ch1", int'(req), 2);
      serve(1); step(1); serve(0); step(1);
      chk(req == 2'b10, "R9 alternation", int'(req), 2);
      desc_nr = 2'b10; step(1); desc_nr = '0;
      chk(dep_go == 1'b0 && dep_go_clr == 1'b1 && req == 2'b00,
          "R10 shared go cleared", int'({dep_go, dep_go_clr, req}), 4);
      first_sel = 1'b0; step(2);
      chk(req == 2'b00, "R10 silent while stalled", int'(req), 0);
      dep_go_set = 1'b1; step(1); dep_go_set = 1'b0; step(1);
      chk(req == 2'b10, "R10 stalled channel resumes first", int'(req), 2);
      serve(1); step(1);
      chk(req == 2'b01, "R10 alternation after resume", int'(req), 1);
      desc_nr = 2'b01; step(1); desc_nr = '0;
      chk(dep_go == 1'b0, "R10 stall on ch0", int'(dep_go), 0);
   endtask

   task automatic t_reserved();
      ch0_mode = 2'b11; ch1_mode = 2'b00;
      go_set = 2'b01; step(1); go_set = '0; step(3);
      chk(req == 2'b00 && go[0] == 1'b1, "R2 reserved mode never requests", int'({go[0], req}), 4);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_single();
      t_multi();
      t_turns();
      t_error();
      t_dep();
      t_reserved();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule